// File: doc/BRIEF.md
# Bank Coincidence Sync Pulse Generator

This block takes one base clock and derives two divided bank clocks from it, bank A and bank C. Each bank has its own 2-bit ratio select. A phase counter runs alongside the two dividers. Its period is the least common multiple of the two ratios, so it marks every base cycle on which the rising edges of both bank clocks fall together.

From that counter the block drives an active-low sync flag. The flag warns of the next coincident rising edge. It falls a lead time before the coincidence, where the lead equals one period of the faster bank clock. It rises again on the same base edge on which both bank clocks rise. The scheme works for any pair of ratios, including pairs that are not integer multiples of each other. The regenerated bank clocks are brought out so that downstream logic and checks can see the edges the flag refers to.

Top module: `bank_sync_gen`

## Requirements
- R1: Bank A select `sel_a` picks the bank A ratio: 0→4, 1→6, 2→8, 3→12 base cycles. With the phase counted from the last restart, `clk_a` is high when phase mod ratio is below half the ratio and low otherwise.
- R2: Bank C select `sel_c` picks the bank C ratio: 0→2, 1→4, 2→6, 3→8 base cycles. `clk_c` follows the same rule as R1, using the bank C ratio.
- R3: When the ratios differ, let L = lcm(ratio A, ratio C) and F = min(ratio A, ratio C). `sync_n` is low exactly when the phase mod L lies in L−F … L−1.
- R4: When the ratios differ, `sync_n` is high outside that window. It returns high on the base edge where phase mod L becomes 0, which is the edge on which both bank clocks rise.
- R5: When the two ratios are equal, `sync_n` stays high on every cycle.
- R6: While reset is asserted, and at phase 0 after it is released, `clk_a`, `clk_c` and `sync_n` are all high. The first low window comes before the first coincidence L cycles later.
- R7: A change on either select restarts both dividers and the phase counter at the next base edge. After that edge the phase is 0 and all three outputs are high.
- R8: Ratios that are not integer multiples of each other (for example 12 against 8, where L = 24) produce a coincidence, with its preceding low window, every L base cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | 2 | Bank A ratio select |
| sel_c | input | 2 | Bank C ratio select |
| clk_a | output | 1 | Regenerated bank A clock |
| clk_c | output | 1 | Regenerated bank C clock |
| sync_n | output | 1 | Active-low warning of the next coincident rising edge |

## Verification
The bench builds the block with its default phase-counter width, which holds the largest least common multiple the ratio sets reach (24). It sweeps all sixteen select pairs in a chain in which every step changes at least one select, so each step also exercises a restart. For each pair it follows the outputs over more than two full coincidence periods. Expected levels come from modular arithmetic on a bench-side phase and from a brute-force search for the least common multiple. The sweep reaches equal ratios, pairs where one ratio divides the other, and the non-multiple pairs such as 12/8 and 8/6.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

  // Width of every phase and ratio value; must hold the largest lcm (24).
  localparam int unsigned PH_W  = 6;
  localparam int unsigned SEL_W = 2;
  // Bound on the Euclid iterations; ample for operands below 2**PH_W.
  localparam int unsigned GCD_ITER = 2 * PH_W;

  typedef logic [PH_W-1:0]  ph_t;
  typedef logic [SEL_W-1:0] sel_t;

  // Bank A ratio choices.
  function automatic ph_t ratio_of_a(input sel_t s);
    case (s)
      2'd0:    return PH_W'(4);
      2'd1:    return PH_W'(6);
      2'd2:    return PH_W'(8);
      default: return PH_W'(12);
    endcase
  endfunction

  // Bank C ratio choices.
  function automatic ph_t ratio_of_c(input sel_t s);
    case (s)
      2'd0:    return PH_W'(2);
      2'd1:    return PH_W'(4);
      2'd2:    return PH_W'(6);
      default: return PH_W'(8);
    endcase
  endfunction

  function automatic int unsigned gcd_of(input int unsigned x, input int unsigned y);
    int unsigned a;
    int unsigned b;
    int unsigned t;
    a = x;
    b = y;
    for (int i = 0; i < GCD_ITER; i++) begin
      if (b != 0) begin
        t = b;
        b = a % b;
        a = t;
      end
    end
    return a;
  endfunction

  // Coincidence period in base cycles.
  function automatic ph_t span_of(input ph_t ra, input ph_t rc);
    int unsigned g;
    int unsigned l;
    g = gcd_of(int'(ra), int'(rc));
    if (g == 0) g = 1;
    l = (int'(ra) * int'(rc)) / g;
    return PH_W'(l);
  endfunction

  // Lead time: one period of the faster bank clock.
  function automatic ph_t lead_of(input ph_t ra, input ph_t rc);
    return (ra < rc) ? ra : rc;
  endfunction

  // Next value of a modulo counter.
  function automatic ph_t wrap_inc(input ph_t cur, input ph_t modulus);
    return (cur >= modulus - PH_W'(1)) ? '0 : cur + PH_W'(1);
  endfunction

  // Level of a 50 % divided clock at a given phase.
  function automatic logic half_high(input ph_t ph, input ph_t ratio);
    return ph < (ratio >> 1);
  endfunction

endpackage

// File: rtl/bsync_phase_div.sv
module bsync_phase_div
  import bsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  ph_t  ratio,
  output logic ph_zero,
  output logic clk_out
);

  ph_t  cnt_q;
  ph_t  cnt_nxt;
  logic out_q;

  assign cnt_nxt = wrap_inc(cnt_q, ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (restart) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      out_q <= half_high(cnt_nxt, ratio);
    end
  end

  assign ph_zero = (cnt_q == '0);
  assign clk_out = out_q;

  // R1/R2: the divider phase never reaches its ratio.
  a_r1_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);

  // R1/R2: a rising edge of the divided clock occurs only at divider phase 0.
  a_r2_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> ph_zero);

endmodule

// File: rtl/bsync_window.sv
module bsync_window
  import bsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  ph_t  ratio_a,
  input  ph_t  ratio_c,
  output logic ph_zero,
  output logic sync_n
);

  ph_t  span;
  ph_t  lead;
  ph_t  win_start;
  logic same;
  ph_t  ph_q;
  ph_t  ph_nxt;
  logic sync_q;

  assign span      = span_of(ratio_a, ratio_c);
  assign lead      = lead_of(ratio_a, ratio_c);
  assign win_start = span - lead;
  assign same      = (ratio_a == ratio_c);
  assign ph_nxt    = wrap_inc(ph_q, span);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sync_q <= 1'b1;
    end else if (restart) begin
      ph_q   <= '0;
      sync_q <= 1'b1;
    end else begin
      ph_q   <= ph_nxt;
      sync_q <= same | (ph_nxt < win_start);
    end
  end

  assign ph_zero = (ph_q == '0);
  assign sync_n  = sync_q;

  // R5: equal ratios keep the flag high.
  a_r5_equal_high: assert property (@(posedge clk) disable iff (!rst_n)
    same |-> sync_q);

  // R3: the flag falls only when the phase enters the lead window.
  a_r3_fall_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_q) |-> (ph_q == win_start));

  // R4: the flag rises only at phase 0.
  a_r4_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> ph_zero);

  // R8: the coincidence phase stays inside the period.
  a_r8_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < span);

endmodule

// File: rtl/bank_sync_gen.sv
module bank_sync_gen
  import bsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_c,
  output logic       clk_a,
  output logic       clk_c,
  output logic       sync_n
);

  sel_t sel_a_q;
  sel_t sel_c_q;
  logic restart;
  ph_t  ratio_a;
  ph_t  ratio_c;
  logic a_zero;
  logic c_zero;
  logic w_zero;

  // Captured selects; a mismatch with the live inputs triggers a restart.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_q <= '0;
      sel_c_q <= '0;
    end else begin
      sel_a_q <= sel_a;
      sel_c_q <= sel_c;
    end
  end

  assign restart = (sel_a != sel_a_q) || (sel_c != sel_c_q);
  assign ratio_a = ratio_of_a(sel_a_q);
  assign ratio_c = ratio_of_c(sel_c_q);

  bsync_phase_div u_div_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .ratio   (ratio_a),
    .ph_zero (a_zero),
    .clk_out (clk_a)
  );

  bsync_phase_div u_div_c (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .ratio   (ratio_c),
    .ph_zero (c_zero),
    .clk_out (clk_c)
  );

  bsync_window u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .ratio_a (ratio_a),
    .ratio_c (ratio_c),
    .ph_zero (w_zero),
    .sync_n  (sync_n)
  );

  // R8: a coincidence of the window counter is a common phase 0 of both dividers.
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    w_zero |-> (a_zero && c_zero));

  // R4: the flag rises only together with high levels on both bank clocks.
  a_r4_rise_with_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> (clk_a && clk_c));

  // R7: a select change brings every output high at the next edge.
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (clk_a && clk_c && sync_n && w_zero));

endmodule

// File: tb/test_bank_sync_gen.sv
`timescale 1ns/1ps
module test_bank_sync_gen;

  logic       clk;
  logic       rst_n;
  logic [1:0] sel_a;
  logic [1:0] sel_c;
  logic       clk_a;
  logic       clk_c;
  logic       sync_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  bank_sync_gen i_bank_sync_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_a  (sel_a),
    .sel_c  (sel_c),
    .clk_a  (clk_a),
    .clk_c  (clk_c),
    .sync_n (sync_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic int ra_of(input int s);
    int t[4] = '{4, 6, 8, 12};
    return t[s];
  endfunction

  function automatic int rc_of(input int s);
    return 2 * (s + 1);
  endfunction

  function automatic int lcm_search(input int a, input int b);
    for (int n = 1; n <= 256; n++)
      if ((n % a == 0) && (n % b == 0)) return n;
    return 0;
  endfunction

  // Compare all outputs at bench phase p for ratios ra, rc.
  task automatic check_phase(input int ra, input int rc, input int p, input bit after_restart);
    int  l;
    int  f;
    int  q;
    bit  exp_s;
    string tag;
    l = lcm_search(ra, rc);
    f = (ra < rc) ? ra : rc;
    q = p % l;
    check(clk_a, ((p % ra) < ra / 2), "R1", "clk_a");
    check(clk_c, ((p % rc) < rc / 2), "R2", "clk_c");
    if (ra == rc) begin
      exp_s = 1'b1; tag = "R5";
    end else if (q >= l - f) begin
      exp_s = 1'b0; tag = ((ra % rc != 0) && (rc % ra != 0)) ? "R3/R8" : "R3";
    end else begin
      exp_s = 1'b1; tag = ((ra % rc != 0) && (rc % ra != 0)) ? "R4/R8" : "R4";
    end
    check(sync_n, exp_s, tag, "sync_n");
    if (after_restart && p == 0)
      check(clk_a & clk_c & sync_n, 1'b1, "R7", "all high after restart");
  endtask

  initial begin
    int prev;
    rst_n = 1'b0;
    sel_a = 2'd0;
    sel_c = 2'd0;
    repeat (3) @(negedge clk);
    // R6: reset state
    check(clk_a, 1'b1, "R6", "clk_a in reset");
    check(clk_c, 1'b1, "R6", "clk_c in reset");
    check(sync_n, 1'b1, "R6", "sync_n in reset");
    rst_n = 1'b1;
    // R6: phase 0 at release, first window precedes the first coincidence
    for (int p = 0; p < 3 * 4 + 1; p++) begin
      check_phase(4, 2, p, 1'b0);
      @(negedge clk);
    end
    // Sweep all pairs; each step changes at least one select (R7 restart).
    prev = 0;
    for (int k = 1; k <= 16; k++) begin
      int c;
      int ra;
      int rc;
      int l;
      c  = k % 16;
      sel_a = 2'(c / 4);
      sel_c = 2'(c % 4);
      ra = ra_of(c / 4);
      rc = rc_of(c % 4);
      l  = lcm_search(ra, rc);
      @(negedge clk);
      for (int p = 0; p < 2 * l + 3; p++) begin
        check_phase(ra, rc, p, 1'b1);
        @(negedge clk);
      end
      prev = c;
    end
    if (prev != 0) n_fail++;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule